// File: doc/BRIEF.md
# Multiply-Shift Accumulate Execution Unit

This unit executes one group of 16-bit DSP operations against a pair of accumulators: a main accumulator and its offset partner. It holds three working registers, the shift count register, the product-high register and the multiplier operand register, plus an unsigned-multiply mode bit and four status flags. Load operations copy one accumulator of the pair into one of the working registers. Arithmetic operations form a 32-bit value, either by multiplying the multiplier operand register by an accumulator or by barrel-shifting an accumulator left by the shift count. The upper half of that value always goes to the product-high register. The lower half is passed through, added to the other accumulator of the pair, or subtracted from it, and the result is sent to an accumulator.

The caller presents a 5-bit sub-opcode with `issue` high for one cycle, together with the two current accumulator values and the select bits. Every state change and write-back takes effect on the clock edge at which `issue` is high. A write-back appears on the outputs after that edge, as a one-cycle pulse on `wbValid`. The caller applies it to the accumulator named by `wbIdx`, using `wbOffset` to pick between the main and offset members of the pair.

Top module: `mulShiftUnit`

## Requirements
- R1: After the active-low reset, the shift count, product-high, multiplier operand, unsigned-mode bit, status flags, write-back data and `wbValid` all read 0.
- R2: Sub-opcode 10100 loads the shift count from the low 4 bits of the source. Sub-opcode 10101 loads product-high from the source. Sub-opcodes 10110 and 10111 load the multiplier operand from the source. The source is `accMain` when `srcSel`=0 and `accOffset` when `srcSel`=1. Loads make no write-back.
- R3: Sub-opcode 10110 clears the unsigned-mode bit to 0 and sub-opcode 10111 sets it to 1. Every later multiply treats both of its operands as two's complement when the bit is 0, and as unsigned when it is 1.
- R4: Multiply operations (11000, 11001, 11011) form the 32-bit product of the multiplier operand register and the operand accumulator, and put bits 31:16 of the product into product-high. The operand accumulator is `accMain` when `srcSel`=0 and `accOffset` when `srcSel`=1. The other accumulator of the pair is the one not selected.
- R5: 11011 writes the low product half. 11001 writes the other accumulator plus the low half. 11000 writes the other accumulator minus the low half. `wbValid` pulses for one cycle after the issuing edge, with `wbOffset`=`dstSel` and `wbIdx`=`accIdx`.
- R6: Shift operations (11010, 11100, 11101) widen the operand accumulator to 32 bits and shift it left by the shift count (0 to 15). The widening is a sign extension when `extMode`=1 and a zero extension when it is 0. Bits 31:16 of the shifted value go to product-high.
- R7: 11010 writes the low shifted half. 11101 writes the other accumulator plus the low half. 11100 writes the other accumulator minus the low half. Write-back follows the same rules as R5.
- R8: Every multiply or shift sets `statusFlags` = {V, C, N, Z} (bit 3 down to bit 0) from the 16-bit result. Z is set when the result is zero, and N is result bit 15. For an add, C is the carry out and V is signed overflow. For a subtract, C is the borrow and V is signed overflow. For a plain transfer, C and V are 0.
- R9: Every load sets Z and N from the full 16-bit source value and leaves C and V unchanged.
- R10: A cycle with `issue`=0, or with any sub-opcode outside 10100 to 11101, changes no register, no flag and no write-back output, and leaves `wbValid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| issue | input | 1 | Sub-opcode is valid this cycle |
| subOp | input | 5 | Operation sub-opcode |
| accIdx | input | IDX_W | Index of the accumulator pair |
| srcSel | input | 1 | 0: main is the source/operand, 1: offset is |
| dstSel | input | 1 | 0: result to main, 1: result to offset |
| extMode | input | 1 | Shift widening: 1 sign, 0 zero |
| accMain | input | DATA_W | Main accumulator value |
| accOffset | input | DATA_W | Offset accumulator value |
| wbValid | output | 1 | Write-back pulse |
| wbIdx | output | IDX_W | Write-back pair index |
| wbOffset | output | 1 | Write-back goes to the offset accumulator |
| wbData | output | DATA_W | Write-back value |
| svOut | output | log2(DATA_W) | Shift count register |
| phOut | output | DATA_W | Product-high register |
| mrOut | output | DATA_W | Multiplier operand register |
| umOut | output | 1 | Unsigned-multiply mode bit |
| statusFlags | output | 4 | {V, C, N, Z} |

## Verification
The bench builds the unit with its default parameters, DATA_W=16 and IDX_W=4. This gives a 4-bit shift count, so random loads of that register reach every shift distance from 0 to 15, and the edge case at 15 is also driven on purpose. At 16 bits, the directed cases can hit the exact boundaries: 0x7FFF plus one for overflow, zero minus one for borrow, 0xFFFF squared in both multiply modes, and 0x8001 shifted fifteen places with both widenings. Random stimulus also mixes undefined sub-opcodes and idle cycles between valid operations.

// File: rtl/msuPkg.sv
package msuPkg;

  typedef enum logic [4:0] {
    OP_LD_SV   = 5'b10100,
    OP_LD_PH   = 5'b10101,
    OP_LD_MR_S = 5'b10110,
    OP_LD_MR_U = 5'b10111,
    OP_MUL_SUB = 5'b11000,
    OP_MUL_ADD = 5'b11001,
    OP_SHF_PAS = 5'b11010,
    OP_MUL_PAS = 5'b11011,
    OP_SHF_SUB = 5'b11100,
    OP_SHF_ADD = 5'b11101
  } msuOp_e;

  typedef enum logic [1:0] {
    CMB_PASS = 2'd0,
    CMB_ADD  = 2'd1,
    CMB_SUB  = 2'd2
  } combine_e;

  typedef struct packed {
    logic     ldSv;
    logic     ldPh;
    logic     ldMr;
    logic     mrUnsigned;
    logic     arith;
    logic     useShift;
    combine_e combine;
  } msuStrobe_t;

endpackage

// File: rtl/msuControl.sv
module msuControl
  import msuPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       issue,
  input  logic [4:0] subOp,
  output msuStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    strobe.combine = CMB_PASS;
    if (issue) begin
      unique case (subOp)
        OP_LD_SV:   strobe.ldSv = 1'b1;
        OP_LD_PH:   strobe.ldPh = 1'b1;
        OP_LD_MR_S: strobe.ldMr = 1'b1;
        OP_LD_MR_U: begin
          strobe.ldMr       = 1'b1;
          strobe.mrUnsigned = 1'b1;
        end
        OP_MUL_SUB: begin
          strobe.arith   = 1'b1;
          strobe.combine = CMB_SUB;
        end
        OP_MUL_ADD: begin
          strobe.arith   = 1'b1;
          strobe.combine = CMB_ADD;
        end
        OP_MUL_PAS: strobe.arith = 1'b1;
        OP_SHF_PAS: begin
          strobe.arith    = 1'b1;
          strobe.useShift = 1'b1;
        end
        OP_SHF_SUB: begin
          strobe.arith    = 1'b1;
          strobe.useShift = 1'b1;
          strobe.combine  = CMB_SUB;
        end
        OP_SHF_ADD: begin
          strobe.arith    = 1'b1;
          strobe.useShift = 1'b1;
          strobe.combine  = CMB_ADD;
        end
        default: strobe = '0;
      endcase
    end
  end

  // At most one kind of register update per issued operation (R2)
  assert_single_target_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.ldSv, strobe.ldPh, strobe.ldMr, strobe.arith}));

  // Nothing is strobed while idle (R10)
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !issue |-> (strobe == '0));

endmodule

// File: rtl/msuDatapath.sv
module msuDatapath
  import msuPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  msuStrobe_t                strobe,
  input  logic                      srcSel,
  input  logic                      dstSel,
  input  logic                      extMode,
  input  logic [IDX_W-1:0]          accIdx,
  input  logic [DATA_W-1:0]         accMain,
  input  logic [DATA_W-1:0]         accOffset,
  output logic                      wbValid,
  output logic [IDX_W-1:0]          wbIdx,
  output logic                      wbOffset,
  output logic [DATA_W-1:0]         wbData,
  output logic [$clog2(DATA_W)-1:0] svReg,
  output logic [DATA_W-1:0]         phReg,
  output logic [DATA_W-1:0]         mrReg,
  output logic                      umReg,
  output logic [3:0]                flagReg
);

  localparam int SV_W   = $clog2(DATA_W);
  localparam int PROD_W = 2 * DATA_W;
  localparam int MSB    = DATA_W - 1;

  logic [DATA_W-1:0]        operand, other;
  logic signed [DATA_W:0]   mulA, mulB;
  logic signed [PROD_W+1:0] mulFull;
  logic [PROD_W-1:0]        shiftSrc, shiftProd, wide;
  logic [DATA_W-1:0]        lowPart, highPart, result;
  logic [DATA_W:0]          sumExt, diffExt;
  logic                     carryBit, ovfBit;
  logic [3:0]               arithFlags, loadFlags;

  assign operand = srcSel ? accOffset : accMain;
  assign other   = srcSel ? accMain : accOffset;

  // Extend both factors by one bit: sign bit when signed mode, zero when unsigned
  assign mulA    = {(~umReg) & mrReg[MSB], mrReg};
  assign mulB    = {(~umReg) & operand[MSB], operand};
  assign mulFull = mulA * mulB;

  assign shiftSrc  = extMode ? {{DATA_W{operand[MSB]}}, operand}
                             : {{DATA_W{1'b0}}, operand};
  assign shiftProd = shiftSrc << svReg;

  assign wide     = strobe.useShift ? shiftProd : mulFull[PROD_W-1:0];
  assign lowPart  = wide[DATA_W-1:0];
  assign highPart = wide[PROD_W-1:DATA_W];

  assign sumExt  = {1'b0, other} + {1'b0, lowPart};
  assign diffExt = {1'b0, other} - {1'b0, lowPart};

  always_comb begin
    result   = lowPart;
    carryBit = 1'b0;
    ovfBit   = 1'b0;
    case (strobe.combine)
      CMB_ADD: begin
        result   = sumExt[DATA_W-1:0];
        carryBit = sumExt[DATA_W];
        ovfBit   = (other[MSB] == lowPart[MSB]) && (result[MSB] != other[MSB]);
      end
      CMB_SUB: begin
        result   = diffExt[DATA_W-1:0];
        carryBit = diffExt[DATA_W];
        ovfBit   = (other[MSB] != lowPart[MSB]) && (result[MSB] != other[MSB]);
      end
      default: ;
    endcase
  end

  assign arithFlags = {ovfBit, carryBit, result[MSB], result == '0};
  assign loadFlags  = {flagReg[3:2], operand[MSB], operand == '0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      svReg    <= '0;
      phReg    <= '0;
      mrReg    <= '0;
      umReg    <= 1'b0;
      flagReg  <= '0;
      wbValid  <= 1'b0;
      wbIdx    <= '0;
      wbOffset <= 1'b0;
      wbData   <= '0;
    end else begin
      wbValid <= strobe.arith;
      if (strobe.ldSv) svReg <= operand[SV_W-1:0];
      if (strobe.ldPh) phReg <= operand;
      if (strobe.ldMr) begin
        mrReg <= operand;
        umReg <= strobe.mrUnsigned;
      end
      if (strobe.ldSv || strobe.ldPh || strobe.ldMr) flagReg <= loadFlags;
      if (strobe.arith) begin
        phReg    <= highPart;
        flagReg  <= arithFlags;
        wbData   <= result;
        wbOffset <= dstSel;
        wbIdx    <= accIdx;
      end
    end
  end

  // A zero-extended shift by zero places leaves nothing in the upper half (R6)
  assert_shift_zero_upper_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.arith && strobe.useShift && !extMode && svReg == '0) |=> (phReg == '0));

  // Write-back only ever follows an arithmetic strobe (R5)
  assert_wb_follows_arith_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.arith |=> !wbValid);

endmodule

// File: rtl/mulShiftUnit.sv
module mulShiftUnit
  import msuPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      issue,
  input  logic [4:0]                subOp,
  input  logic [IDX_W-1:0]          accIdx,
  input  logic                      srcSel,
  input  logic                      dstSel,
  input  logic                      extMode,
  input  logic [DATA_W-1:0]         accMain,
  input  logic [DATA_W-1:0]         accOffset,
  output logic                      wbValid,
  output logic [IDX_W-1:0]          wbIdx,
  output logic                      wbOffset,
  output logic [DATA_W-1:0]         wbData,
  output logic [$clog2(DATA_W)-1:0] svOut,
  output logic [DATA_W-1:0]         phOut,
  output logic [DATA_W-1:0]         mrOut,
  output logic                      umOut,
  output logic [3:0]                statusFlags
);

  msuStrobe_t strobe;

  msuControl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .issue  (issue),
    .subOp  (subOp),
    .strobe (strobe)
  );

  msuDatapath #(.DATA_W(DATA_W), .IDX_W(IDX_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .srcSel    (srcSel),
    .dstSel    (dstSel),
    .extMode   (extMode),
    .accIdx    (accIdx),
    .accMain   (accMain),
    .accOffset (accOffset),
    .wbValid   (wbValid),
    .wbIdx     (wbIdx),
    .wbOffset  (wbOffset),
    .wbData    (wbData),
    .svReg     (svOut),
    .phReg     (phOut),
    .mrReg     (mrOut),
    .umReg     (umOut),
    .flagReg   (statusFlags)
  );

  assert_um_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (issue && subOp == 5'b10111) |=> umOut);

  assert_um_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (issue && subOp == 5'b10110) |=> !umOut);

  assert_load_keeps_cv_R9: assert property (@(posedge clk) disable iff (!rstN)
    (issue && subOp[4:2] == 3'b101) |=> ($stable(statusFlags[3:2]) && !wbValid));

  assert_transfer_no_cv_R8: assert property (@(posedge clk) disable iff (!rstN)
    (issue && (subOp == 5'b11010 || subOp == 5'b11011)) |=> (statusFlags[3:2] == 2'b00));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !issue |=> ($stable(phOut) && $stable(mrOut) && $stable(svOut) && $stable(umOut)
                && $stable(statusFlags) && !wbValid));

endmodule

// File: tb/sim_mulShiftUnit.sv
`timescale 1ns/1ps
module sim_mulShiftUnit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issue = 1'b0;
  logic [4:0]  subOp = '0;
  logic [3:0]  accIdx = '0;
  logic        srcSel = 1'b0, dstSel = 1'b0, extMode = 1'b0;
  logic [15:0] accMain = '0, accOffset = '0;
  logic        wbValid, wbOffset, umOut;
  logic [3:0]  wbIdx, svOut, statusFlags;
  logic [15:0] wbData, phOut, mrOut;

  int passCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  // bench model state
  logic [3:0]  mSv = '0;
  logic [15:0] mPh = '0, mMr = '0, mWbData = '0;
  logic        mUm = 1'b0, mWbValid = 1'b0, mWbOff = 1'b0;
  logic [3:0]  mFlags = '0, mWbIdx = '0;

  always #2 clk = ~clk;

  mulShiftUnit u0 (
    .clk(clk), .rstN(rstN), .issue(issue), .subOp(subOp), .accIdx(accIdx),
    .srcSel(srcSel), .dstSel(dstSel), .extMode(extMode),
    .accMain(accMain), .accOffset(accOffset),
    .wbValid(wbValid), .wbIdx(wbIdx), .wbOffset(wbOffset), .wbData(wbData),
    .svOut(svOut), .phOut(phOut), .mrOut(mrOut), .umOut(umOut),
    .statusFlags(statusFlags)
  );

  function automatic logic [31:0] benchMul(logic [15:0] a, logic [15:0] b, logic uns);
    longint pa, pb;
    pa = uns ? longint'(a) : longint'($signed(a));
    pb = uns ? longint'(b) : longint'($signed(b));
    return 32'(pa * pb);
  endfunction

  function automatic logic [31:0] benchShift(logic [15:0] a, logic [3:0] n, logic sx);
    logic [31:0] w;
    w = sx ? {{16{a[15]}}, a} : {16'h0, a};
    return w << n;
  endfunction

  task automatic checkAll(string tag);
    logic [74:0] got, exp;
    got = {svOut, phOut, mrOut, umOut, statusFlags, wbValid, wbOffset, wbIdx, wbData};
    exp = {mSv, mPh, mMr, mUm, mFlags, mWbValid, mWbOff, mWbIdx, mWbData};
    if (got === exp) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s: sv/ph/mr/um/flags/wbv/wbo/wbi/wbd actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic runOp(logic [4:0] op, logic ss, logic ds, logic xm,
                       logic [15:0] am, logic [15:0] ao, logic [3:0] idx, string tag);
    logic [15:0] opnd, oth, lo, res;
    logic [31:0] wide;
    longint us, sg;
    bit c, v;
    @(negedge clk);
    issue = 1'b1; subOp = op; srcSel = ss; dstSel = ds; extMode = xm;
    accMain = am; accOffset = ao; accIdx = idx;
    opnd = ss ? ao : am;
    oth  = ss ? am : ao;
    mWbValid = 1'b0;
    if (op >= 5'b10100 && op <= 5'b10111) begin
      mFlags = {mFlags[3:2], opnd[15], opnd == 16'h0};
      case (op)
        5'b10100: mSv = opnd[3:0];
        5'b10101: mPh = opnd;
        5'b10110: begin mMr = opnd; mUm = 1'b0; end
        default:  begin mMr = opnd; mUm = 1'b1; end
      endcase
    end else if (op >= 5'b11000 && op <= 5'b11101) begin
      if (op == 5'b11010 || op == 5'b11100 || op == 5'b11101) wide = benchShift(opnd, mSv, xm);
      else wide = benchMul(mMr, opnd, mUm);
      lo = wide[15:0];
      mPh = wide[31:16];
      c = 1'b0; v = 1'b0; res = lo;
      if (op == 5'b11001 || op == 5'b11101) begin
        us = longint'(oth) + longint'(lo);
        sg = longint'($signed(oth)) + longint'($signed(lo));
        res = 16'(us); c = us > 65535; v = (sg > 32767) || (sg < -32768);
      end else if (op == 5'b11000 || op == 5'b11100) begin
        us = longint'(oth) - longint'(lo);
        sg = longint'($signed(oth)) - longint'($signed(lo));
        res = 16'(us); c = us < 0; v = (sg > 32767) || (sg < -32768);
      end
      mFlags = {v, c, res[15], res == 16'h0};
      mWbValid = 1'b1; mWbOff = ds; mWbIdx = idx; mWbData = res;
    end
    @(posedge clk);
    #1;
    checkAll(tag);
    issue = 1'b0;
  endtask

  task automatic idleCycle(string tag);
    @(negedge clk);
    issue = 1'b0;
    accMain = 16'(~accMain); accOffset = 16'(~accOffset);
    mWbValid = 1'b0;
    @(posedge clk);
    #1;
    checkAll(tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
      $finish;
    end
  end

  initial begin
    logic [4:0] codes [10];
    void'($urandom(32'd20240611));
    codes = '{5'b10100, 5'b10101, 5'b10110, 5'b10111, 5'b11000,
              5'b11001, 5'b11010, 5'b11011, 5'b11100, 5'b11101};
    repeat (3) @(posedge clk);
    #1;
    checkAll("R1 reset state");
    @(negedge clk);
    rstN = 1'b1;

    // R2 loads from either accumulator
    runOp(5'b10100, 1'b1, 1'b0, 1'b0, 16'h1230, 16'hABC5, 4'd1, "R2 load shift count from offset");
    runOp(5'b10101, 1'b0, 1'b0, 1'b0, 16'h8000, 16'h0001, 4'd2, "R2 R9 load product-high, N set");
    runOp(5'b10110, 1'b1, 1'b0, 1'b0, 16'h5555, 16'h0000, 4'd2, "R2 R9 load operand zero, Z set");
    // R3 / R4 signed and unsigned squares of 0xFFFF
    runOp(5'b10110, 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'h0, 4'd0, "R3 signed operand load");
    runOp(5'b11011, 1'b0, 1'b1, 1'b0, 16'hFFFF, 16'h0, 4'd3, "R4 R5 signed multiply transfer");
    runOp(5'b10111, 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'h0, 4'd0, "R3 unsigned operand load");
    runOp(5'b11011, 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'h0, 4'd4, "R4 R5 unsigned multiply transfer");
    // R8 add overflow and subtract borrow
    runOp(5'b10110, 1'b0, 1'b0, 1'b0, 16'h0001, 16'h0, 4'd0, "R2 operand = 1");
    runOp(5'b11001, 1'b0, 1'b0, 1'b0, 16'h0001, 16'h7FFF, 4'd5, "R5 R8 multiply-add signed overflow");
    runOp(5'b11000, 1'b0, 1'b1, 1'b0, 16'h0001, 16'h0000, 4'd6, "R5 R8 multiply-subtract borrow");
    // R6 / R7 shift 0x8001 by 15 both widenings
    runOp(5'b10100, 1'b0, 1'b0, 1'b0, 16'h000F, 16'h0, 4'd0, "R2 shift count 15");
    runOp(5'b11010, 1'b0, 1'b0, 1'b1, 16'h8001, 16'h0, 4'd7, "R6 R7 sign-extended shift transfer");
    runOp(5'b11010, 1'b0, 1'b0, 1'b0, 16'h8001, 16'h0, 4'd7, "R6 R7 zero-extended shift transfer");
    runOp(5'b11101, 1'b1, 1'b0, 1'b1, 16'h1234, 16'h0003, 4'd8, "R7 R8 shift-add");
    runOp(5'b11100, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0001, 4'd9, "R7 R8 shift-subtract borrow");
    runOp(5'b10100, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0, 4'd0, "R9 load zero count keeps C V");
    runOp(5'b11010, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0, 4'd1, "R6 R8 zero result Z set");
    // R10 idle and undefined codes
    idleCycle("R10 idle cycle");
    runOp(5'b00011, 1'b0, 1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 4'd2, "R10 undefined sub-opcode low");
    runOp(5'b11110, 1'b1, 1'b1, 1'b1, 16'h7777, 16'h8888, 4'd3, "R10 undefined sub-opcode high");

    for (int i = 0; i < 400; i++) begin
      logic [4:0] op;
      int pick;
      pick = $urandom_range(0, 11);
      if (pick < 10) op = codes[pick];
      else op = 5'($urandom_range(0, 19));
      if ($urandom_range(0, 7) == 0) idleCycle("R10 random idle");
      runOp(op, 1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
            4'($urandom), "R4 R5 R6 R7 R8 R9 random mix");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

endmodule